// File: doc/BRIEF.md
# Timer-Driven PWM Output Compare Channel

This block pairs an up-counting time base with one output compare channel that drives one output pin. The time base counts qualified increments (`tick`), runs from zero up to a programmable period value, and returns to zero on the next increment. In PWM mode the channel raises the pin at every period boundary and drops it when the count reaches the active duty value. The duty value is double-buffered. Software writes a shadow register, and the active duty register takes that value only at a period boundary, so a period that has already started keeps its waveform.

The block also has a simple compare mode, in which a match raises a sticky compare flag and sets the pin. A sleep input freezes the whole block in place. An idle input halts the time base, the channel, or both, depending on their idle-stop controls. The prescaler, the clock source and the interrupt controller are outside the block. The caller supplies the increment strobe and reads the two request outputs.

Top module: `oc_pwm_channel`

## Requirements
- R1: The counter starts at 0. On each qualified increment it adds 1, and on the increment after it equals `period` it returns to 0. A PWM period therefore lasts `period`+1 increments. An increment is qualified when `tick`=1, `tmr_en`=1, `sleep`=0, and `idle`=0 or `tmr_idle_stop`=0.
- R2: The increment that returns the counter to 0 sets `tmr_flag`. The flag stays set until a `tmr_flag_clr` pulse clears it, and a set in the same cycle wins over a clear. `tmr_irq` = `tmr_flag` AND `tmr_ie`.
- R3: In PWM mode (`mode`=2'b10) the pin goes high at each period boundary. It goes low on the increment where the count reaches the active duty D. For 0 < D <= `period`, the pin is high for D increments of every period.
- R4: In PWM mode with an active duty of 0, the pin stays low for the whole period.
- R5: In PWM mode with an active duty greater than `period`, the pin stays high for the whole period.
- R6: In PWM mode the active duty loads from the shadow register only at a period boundary. A shadow write in the middle of a period does not change that period's waveform. It takes effect from the next period.
- R7: In PWM mode `cmp_flag` is never set.
- R8: In compare mode (`mode`=2'b01) the active value follows the shadow register. The increment where the count reaches it sets the sticky `cmp_flag` and drives the pin high. `cmp_flag_clr` clears the flag, and `cmp_irq` = `cmp_flag` AND `cmp_ie`. With `mode`=2'b00 or 2'b11 the pin is driven low and `cmp_flag` is never set.
- R9: While `sleep`=1 the counter, the pin, both duty registers and both flags hold their values. Operation resumes from that state once `sleep` returns to 0.
- R10: While `idle`=1, the counter halts if `tmr_idle_stop`=1. The channel (pin, duty load, compare) halts if `ch_idle_stop`=1, `tmr_en`=0 or `tmr_idle_stop`=1. Otherwise both keep running.
- R11: After a synchronous reset, the count is 0, the pin is low, both duty registers are 0, and both flags and both requests are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Increment strobe from the external prescaler |
| tmr_en | input | 1 | Time base enable |
| tmr_idle_stop | input | 1 | Time base halts during idle when 1 |
| sleep | input | 1 | Freezes all state when 1 |
| idle | input | 1 | Idle state indicator |
| ch_idle_stop | input | 1 | Channel halts during idle when 1 |
| mode | input | 2 | 00 off, 01 compare, 10 PWM, 11 off |
| period | input | W | Period value |
| duty_wr | input | 1 | Shadow duty write strobe |
| duty_wdata | input | W | Shadow duty write data |
| tmr_flag_clr | input | 1 | Clears the timer flag |
| cmp_flag_clr | input | 1 | Clears the compare flag |
| tmr_ie | input | 1 | Timer request enable |
| cmp_ie | input | 1 | Compare request enable |
| tmr_count | output | W | Current counter value |
| pwm_out | output | 1 | Output pin |
| tmr_flag | output | 1 | Sticky timer flag |
| cmp_flag | output | 1 | Sticky compare flag |
| tmr_irq | output | 1 | Timer request |
| cmp_irq | output | 1 | Compare request |

## Verification
The duty sweep covers 0, 1, the period value, one more than the period value, a midrange value and a value far above the period. These values separate the forced-low case, the normal high-then-low shape at both ends, and the forced-high case. The counts of high cycles per period also expose any off-by-one error at the boundary. A shadow write at count 2 of a period with duty 4 shows whether the active duty is latched only at rollover. Sleep, the idle-stop combinations and a tick that fires every other cycle show which stalls freeze the counter, which freeze the pin, and that the waveform depends only on qualified increments. A behavioural reference model is compared with every output on every cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_OFF  = 2'b00,
    OC_CMP  = 2'b01,
    OC_PWM  = 2'b10,
    OC_RSVD = 2'b11
  } oc_mode_e;
endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         tmr_en,
  input  logic         sleep,
  input  logic         idle,
  input  logic         tmr_idle_stop,
  input  logic [W-1:0] period,
  input  logic         tflag_clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         step,
  output logic         wrap,
  output logic         tflag_q
);
  logic halted;

  always_comb begin
    halted  = sleep || !tmr_en || (idle && tmr_idle_stop);
    step    = tick && !halted;
    wrap    = step && (cnt_q == period);
    cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tflag_q <= 1'b0;
    end else if (!sleep) begin
      if (wrap)           tflag_q <= 1'b1;
      else if (tflag_clr) tflag_q <= 1'b0;
    end
  end

  // R1: the increment after count == period returns the count to zero
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q == period) |=> (cnt_q == '0));

  // R2: a rollover always leaves the timer flag set
  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q == period) |=> tflag_q);
endmodule

// File: rtl/oc_duty_buf.sv
module oc_duty_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         ch_run,
  input  logic         pwm_mode,
  input  logic         wrap,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] act_q
);
  logic load;

  always_comb begin
    load = ch_run && (pwm_mode ? wrap : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (!sleep && wr_en) begin
      shadow_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (load) begin
      act_q <= shadow_q;
    end
  end

  // R6: in PWM mode the active duty holds between period boundaries
  p_act_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !(ch_run && wrap)) |=> $stable(act_q));

  // R9: sleep freezes both duty registers
  p_duty_sleep_r9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(act_q) && $stable(shadow_q)));
endmodule

// File: rtl/oc_wave.sv
module oc_wave
  import oc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  oc_mode_e     mode,
  input  logic         ch_run,
  input  logic         step,
  input  logic         wrap,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] act_q,
  input  logic [W-1:0] shadow_q,
  input  logic         cflag_clr,
  output logic         pin_q,
  output logic         cflag_q
);
  logic match;
  logic pin_d;

  always_comb begin
    match = ch_run && step && (cnt_nxt == act_q);
    pin_d = pin_q;
    unique case (mode)
      OC_PWM: begin
        if (ch_run && wrap) pin_d = (shadow_q != '0);
        else if (match)     pin_d = 1'b0;
      end
      OC_CMP: begin
        if (match) pin_d = 1'b1;
      end
      default: begin
        if (ch_run) pin_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cflag_q <= 1'b0;
    end else if (!sleep) begin
      if (mode == OC_CMP && match) cflag_q <= 1'b1;
      else if (cflag_clr)          cflag_q <= 1'b0;
    end
  end

  // R3: in PWM mode the pin can rise only at a period boundary
  p_rise_at_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_PWM && !(ch_run && wrap) && !pin_q) |=> !pin_q);

  // R7: PWM mode never sets the compare flag
  p_no_cflag_pwm_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_PWM && !cflag_q) |=> !cflag_q);
endmodule

// File: rtl/oc_pwm_channel.sv
module oc_pwm_channel
  import oc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         tmr_en,
  input  logic         tmr_idle_stop,
  input  logic         sleep,
  input  logic         idle,
  input  logic         ch_idle_stop,
  input  logic [1:0]   mode,
  input  logic [W-1:0] period,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_wdata,
  input  logic         tmr_flag_clr,
  input  logic         cmp_flag_clr,
  input  logic         tmr_ie,
  input  logic         cmp_ie,
  output logic [W-1:0] tmr_count,
  output logic         pwm_out,
  output logic         tmr_flag,
  output logic         cmp_flag,
  output logic         tmr_irq,
  output logic         cmp_irq
);
  oc_mode_e     mode_e;
  logic         ch_run;
  logic         step;
  logic         wrap;
  logic [W-1:0] cnt_nxt;
  logic [W-1:0] shadow_q;
  logic [W-1:0] act_q;

  always_comb begin
    mode_e = oc_mode_e'(mode);
    ch_run = !sleep && !(idle && (ch_idle_stop || !tmr_en || tmr_idle_stop));
  end

  oc_timebase #(.W(W)) u_tb (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .tmr_en       (tmr_en),
    .sleep        (sleep),
    .idle         (idle),
    .tmr_idle_stop(tmr_idle_stop),
    .period       (period),
    .tflag_clr    (tmr_flag_clr),
    .cnt_q        (tmr_count),
    .cnt_nxt      (cnt_nxt),
    .step         (step),
    .wrap         (wrap),
    .tflag_q      (tmr_flag)
  );

  oc_duty_buf #(.W(W)) u_duty (
    .clk     (clk),
    .rst     (rst),
    .sleep   (sleep),
    .ch_run  (ch_run),
    .pwm_mode(mode_e == OC_PWM),
    .wrap    (wrap),
    .wr_en   (duty_wr),
    .wr_data (duty_wdata),
    .shadow_q(shadow_q),
    .act_q   (act_q)
  );

  oc_wave #(.W(W)) u_wave (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .mode     (mode_e),
    .ch_run   (ch_run),
    .step     (step),
    .wrap     (wrap),
    .cnt_nxt  (cnt_nxt),
    .act_q    (act_q),
    .shadow_q (shadow_q),
    .cflag_clr(cmp_flag_clr),
    .pin_q    (pwm_out),
    .cflag_q  (cmp_flag)
  );

  always_comb begin
    tmr_irq = tmr_flag && tmr_ie;
    cmp_irq = cmp_flag && cmp_ie;
  end

  // R9: sleep freezes the counter, the pin and both flags
  p_sleep_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(tmr_count) && $stable(pwm_out) && $stable(tmr_flag) && $stable(cmp_flag)));

  // R10: idle with the channel stopped holds the pin
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (idle && ch_idle_stop) |=> $stable(pwm_out));
endmodule

// File: tb/tb_oc_pwm_channel.sv
module tb_oc_pwm_channel;
  localparam int W = 8;
  localparam int P = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, tmr_en = 1'b0, tmr_idle_stop = 1'b0, sleep = 1'b0, idle = 1'b0;
  logic ch_idle_stop = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] period = W'(P);
  logic duty_wr = 1'b0;
  logic [W-1:0] duty_wdata = '0;
  logic tmr_flag_clr = 1'b0, cmp_flag_clr = 1'b0, tmr_ie = 1'b0, cmp_ie = 1'b0;
  logic [W-1:0] tmr_count;
  logic pwm_out, tmr_flag, cmp_flag, tmr_irq, cmp_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oc_pwm_channel #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_shadow = 0, m_act = 0;
  bit m_pin = 0, m_tf = 0, m_cf = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_shadow = 0; m_act = 0; m_pin = 0; m_tf = 0; m_cf = 0;
    end else begin
      bit adv, run, roll, hit;
      int nxt;
      adv  = tick && tmr_en && !sleep && !(idle && tmr_idle_stop);
      run  = !sleep && !(idle && (ch_idle_stop || !tmr_en || tmr_idle_stop));
      roll = adv && (m_cnt == int'(period));
      nxt  = roll ? 0 : (m_cnt + 1) % (1 << W);
      hit  = run && adv && (nxt == m_act);
      if (mode == 2'b10) begin
        if (run && roll) m_pin = (m_shadow != 0);
        else if (hit) m_pin = 0;
      end else if (mode == 2'b01) begin
        if (hit) m_pin = 1;
      end else if (run) begin
        m_pin = 0;
      end
      if (!sleep) begin
        if (roll) m_tf = 1; else if (tmr_flag_clr) m_tf = 0;
        if (mode == 2'b01 && hit) m_cf = 1; else if (cmp_flag_clr) m_cf = 0;
      end
      if (run && (mode == 2'b10 ? roll : 1'b1)) m_act = m_shadow;
      if (!sleep && duty_wr) m_shadow = int'(duty_wdata);
      if (adv) m_cnt = nxt;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(tmr_count) == m_cnt, "R1 count", int'(tmr_count), m_cnt);
      chk(pwm_out == m_pin, "R3 pin", pwm_out, m_pin);
      chk(tmr_flag == m_tf && tmr_irq == (m_tf && tmr_ie), "R2 timer flag", tmr_flag, m_tf);
      chk(cmp_flag == m_cf && cmp_irq == (m_cf && cmp_ie), "R8 compare flag", cmp_flag, m_cf);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_duty(input int d);
    @(negedge clk); duty_wr = 1'b1; duty_wdata = W'(d);
    @(negedge clk); duty_wr = 1'b0;
  endtask

  task automatic wait_count(input int c);
    do @(negedge clk); while (int'(tmr_count) != c);
  endtask

  task automatic measure(input int d, input string tag);
    int hi = 0;
    int exp;
    wr_duty(d);
    wait_count(0);
    for (int i = 0; i < 3 * (P + 1); i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_out) hi++;
    end
    exp = 3 * ((d < P + 1) ? d : P + 1);
    chk(hi == exp, tag, hi, exp);
  endtask

  initial begin
    int hi;
    bit held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(tmr_count == 0 && !pwm_out && !tmr_flag && !cmp_flag && !tmr_irq && !cmp_irq,
        "R11 reset", {tmr_count, pwm_out, tmr_flag, cmp_flag}, 0);

    tick = 1'b1; tmr_en = 1'b1; mode = 2'b10; tmr_ie = 1'b1; cmp_ie = 1'b1;
    measure(0,   "R4 duty 0");
    measure(1,   "R3 duty 1");
    measure(P,   "R3 duty period");
    measure(P+1, "R5 duty period+1");
    measure(4,   "R3 duty mid");
    measure(200, "R5 duty far above");

    // R6: write mid-period, current period keeps duty 4
    wr_duty(4);
    wait_count(0);
    wait_count(0);
    hi = 0;
    for (int i = 0; i < P + 1; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_out) hi++;
      if (i == 2) begin duty_wr = 1'b1; duty_wdata = 8'd7; end
      if (i == 3) duty_wr = 1'b0;
    end
    chk(hi == 4, "R6 current period", hi, 4);
    hi = 0;
    for (int i = 0; i < P + 1; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == 7, "R6 next period", hi, 7);

    // R2: clear and re-set of the timer flag
    wait_count(5);
    tmr_flag_clr = 1'b1; @(negedge clk); tmr_flag_clr = 1'b0;
    chk(!tmr_flag && !tmr_irq, "R2 cleared", tmr_flag, 0);
    wait_count(0);
    chk(tmr_flag && tmr_irq, "R2 set at rollover", tmr_flag, 1);
    // R7: no compare flag after all PWM periods
    chk(!cmp_flag, "R7 no compare flag in PWM", cmp_flag, 0);

    // R8: compare mode
    mode = 2'b01;
    wr_duty(5);
    wait_count(5);
    chk(cmp_flag && cmp_irq && pwm_out, "R8 match", {cmp_flag, pwm_out}, 3);
    cmp_flag_clr = 1'b1; @(negedge clk); cmp_flag_clr = 1'b0;
    chk(!cmp_flag, "R8 clear", cmp_flag, 0);
    mode = 2'b00;
    @(negedge clk);
    chk(!pwm_out, "R8 off mode low", pwm_out, 0);

    // R9: sleep freezes
    mode = 2'b10;
    wr_duty(4);
    wait_count(0);
    wait_count(2);
    sleep = 1'b1;
    held = pwm_out;
    repeat (12) begin
      @(negedge clk);
      chk(tmr_count == 2 && pwm_out == held, "R9 frozen", tmr_count, 2);
    end
    sleep = 1'b0;
    @(negedge clk);
    chk(tmr_count == 3, "R9 resume", tmr_count, 3);

    // R10: idle combinations
    idle = 1'b1; ch_idle_stop = 1'b1;
    held = pwm_out;
    repeat (15) @(negedge clk);
    chk(pwm_out == held && tmr_count != 3, "R10 channel stop, timer runs", pwm_out, held);
    tmr_idle_stop = 1'b1;
    @(negedge clk);
    hi = int'(tmr_count);
    repeat (8) @(negedge clk);
    chk(int'(tmr_count) == hi, "R10 timer stop", tmr_count, hi);
    tmr_idle_stop = 1'b0; ch_idle_stop = 1'b0;
    repeat (25) @(negedge clk);
    idle = 1'b0;
    tmr_en = 1'b0;
    @(negedge clk);
    hi = int'(tmr_count);
    repeat (6) @(negedge clk);
    chk(int'(tmr_count) == hi, "R1 disabled timer holds", tmr_count, hi);
    tmr_en = 1'b1;

    // R1: sparse ticks, model compares every cycle
    for (int i = 0; i < 80; i++) begin
      tick = i[0];
      @(negedge clk);
    end
    tick = 1'b1;
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule